// File: doc/BRIEF.md
# Width-Converting FIFO with Mark and Rewind

This block is a single-clock first-in first-out buffer whose write side and read side each run at either 9 or 18 bits. The two widths are chosen independently, so a narrow producer can feed a wide consumer, a wide producer can feed a narrow consumer, or both sides can share one width. When the widths differ, an 18-bit word is split into bytes, or built from bytes, in an order picked by a byte-order setting. Storage is kept in 9-bit units, so a parameter sets the depth in bytes.

A reader can hold a mark on the current read position and later rewind to it. This replays a stretch of data as many times as needed. While the mark is held, the bytes from the mark onward are protected from being overwritten. The flags run in one of two modes. In standard mode they report empty and full, and every word needs a read request. In fall-through mode they report output-valid and input-ready, and the oldest word moves to the output by itself. Master reset loads the widths, byte order and flag mode from the configuration pins. Partial reset empties the buffer and keeps that configuration.

Top module: `fifo_busmatch`

## Requirements
- R1: While `mrst` is high, the configuration pins are captured and the buffer is emptied; `dout` is 0 and `half_full` is 0. Standard mode then shows `out_flag`=1 and `in_flag`=0. Fall-through mode shows `out_flag`=0 and `in_flag`=1. The configuration pins have no effect at any other time.
- R2: With 9-bit write and 9-bit read, bytes leave in write order on `dout[8:0]`, and `dout[17:9]` is 0.
- R3: With 18-bit write and 18-bit read, each word leaves whole and in write order.
- R4: With 9-bit write and 18-bit read, a word is available only once two bytes are stored. In big-endian order (`cfg_big_end`=1) the earlier byte goes to `dout[17:9]`. In little-endian order it goes to `dout[8:0]`.
- R5: With 18-bit write and 9-bit read, each word gives two reads. Big-endian order gives `din[17:9]` first. Little-endian order gives `din[8:0]` first.
- R6: While `wcs` is 0, `wen` has no effect on the stored data.
- R7: In standard mode, while `rcs` is 0, `ren` neither changes `dout` nor removes data.
- R8: The capacity is `DEPTH9` bytes. In standard mode `in_flag` (full) is 1 when the free bytes are fewer than the write width in bytes. A write made while it is 1 is dropped.
- R9: `half_full` is 1 exactly when more than `DEPTH9/2` bytes are stored beyond the read pointer.
- R10: In fall-through mode, the oldest word reaches `dout` with `out_flag`=1 without any read request, and it stays there until a read with `rcs`=1. A read then shows the next word, or clears `out_flag` if none is stored.
- R11: On the rising of `mark`, the position of the next word to be read is recorded. While `mark` stays high, a one-cycle `rt` rewinds reading to that position. `rt` has no effect while `mark` is low.
- R12: While `mark` is high, fullness is counted from the marked position and not from the read pointer. Releasing `mark` frees the space that has already been read.
- R13: `prst` empties the buffer and cancels the mark, but keeps the widths, byte order and flag mode captured at the last master reset.
- R14: In standard mode, a read while `out_flag` (empty) is 1 leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, captures configuration |
| prst | input | 1 | Partial reset, synchronous, keeps configuration |
| cfg_in_wide | input | 1 | 1 = 18-bit write side, 0 = 9-bit |
| cfg_out_wide | input | 1 | 1 = 18-bit read side, 0 = 9-bit |
| cfg_big_end | input | 1 | 1 = upper byte transferred first |
| cfg_fwft | input | 1 | 1 = fall-through flags, 0 = standard flags |
| wen | input | 1 | Write request |
| wcs | input | 1 | Write select; writes ignored when 0 |
| din | input | 18 | Write data; 9-bit mode uses din[8:0] |
| ren | input | 1 | Read request |
| rcs | input | 1 | Read select; reads ignored when 0 |
| mark | input | 1 | Level: rising records position, high holds mark |
| rt | input | 1 | Rewind to the marked position |
| dout | output | 18 | Read data; 9-bit mode uses dout[8:0] |
| out_flag | output | 1 | Standard: empty. Fall-through: output valid |
| in_flag | output | 1 | Standard: full. Fall-through: input ready |
| half_full | output | 1 | More than half the bytes occupied |

## Verification
The bench targets the byte order in both conversion directions. A swapped lane would return bytes reversed, and a wide read taken from a single stored byte would flag data too early. It fills the buffer to the exact byte capacity and crosses the half-way point one byte at a time, so an off-by-one in the occupancy compare shows up as a flag one write late or early. It rewinds to a mark and refills while the mark is held, so a design that counts fullness from the read pointer would report space it does not have. It also issues a partial reset with different configuration pins present; a design that reloads the configuration there would change byte order.

// File: rtl/fifo_busmatch.sv
module fifo_busmatch #(
  parameter int DEPTH9 = 64
) (
  input  logic        clk,
  input  logic        mrst,
  input  logic        prst,
  input  logic        cfg_in_wide,
  input  logic        cfg_out_wide,
  input  logic        cfg_big_end,
  input  logic        cfg_fwft,
  input  logic        wen,
  input  logic        wcs,
  input  logic [17:0] din,
  input  logic        ren,
  input  logic        rcs,
  input  logic        mark,
  input  logic        rt,
  output logic [17:0] dout,
  output logic        out_flag,
  output logic        in_flag,
  output logic        half_full
);
  localparam int AW = $clog2(DEPTH9);
  localparam int PW = AW + 1;

  logic          in_w, out_w, big, fwft;
  logic [8:0]    mem [DEPTH9];
  logic [PW-1:0] wptr, rptr, mptr, hptr;
  logic          mark_q, ov;

  wire [PW-1:0] ib    = in_w  ? PW'(2) : PW'(1);
  wire [PW-1:0] ob    = out_w ? PW'(2) : PW'(1);
  wire [PW-1:0] base  = mark_q ? mptr : rptr;
  wire [PW-1:0] used  = wptr - base;
  wire [PW-1:0] avail = wptr - rptr;
  wire          full  = (PW'(DEPTH9) - used) < ib;
  wire          empty = avail < ob;

  wire wr_go  = wen && wcs && !full;
  wire rt_go  = rt && mark_q;
  wire rd_req = ren && rcs;
  wire fetch  = !rt_go && !empty && (fwft ? (!ov || rd_req) : rd_req);

  wire [AW-1:0] wa0 = wptr[AW-1:0];
  wire [AW-1:0] wa1 = wa0 + AW'(1);
  wire [AW-1:0] ra0 = rptr[AW-1:0];
  wire [AW-1:0] ra1 = ra0 + AW'(1);
  wire [8:0]    rb0 = mem[ra0];
  wire [8:0]    rb1 = mem[ra1];

  wire [8:0]  wb0   = (in_w && big) ? din[17:9] : din[8:0];
  wire [8:0]  wb1   = big ? din[8:0] : din[17:9];
  wire [17:0] rword = out_w ? (big ? {rb0, rb1} : {rb1, rb0}) : {9'd0, rb0};

  always_ff @(posedge clk) begin
    if (wr_go && !mrst && !prst) begin
      mem[wa0] <= wb0;
      if (in_w) mem[wa1] <= wb1;
    end
  end

  always_ff @(posedge clk) begin
    if (mrst || prst) begin
      if (mrst) begin
        in_w  <= cfg_in_wide;
        out_w <= cfg_out_wide;
        big   <= cfg_big_end;
        fwft  <= cfg_fwft;
      end
      wptr   <= '0;
      rptr   <= '0;
      mptr   <= '0;
      hptr   <= '0;
      mark_q <= 1'b0;
      ov     <= 1'b0;
      dout   <= '0;
    end else begin
      mark_q <= mark;
      if (mark && !mark_q) mptr <= (fwft && ov) ? hptr : rptr;
      if (wr_go) wptr <= wptr + ib;
      if (rt_go) begin
        rptr <= mptr;
        if (fwft) ov <= 1'b0;
      end else if (fetch) begin
        rptr <= rptr + ob;
        hptr <= rptr;
        dout <= rword;
        if (fwft) ov <= 1'b1;
      end else if (fwft && rd_req && ov) begin
        ov <= 1'b0;
      end
    end
  end

  assign out_flag  = fwft ? ov : empty;
  assign in_flag   = fwft ? !full : full;
  assign half_full = avail > PW'(DEPTH9 / 2);
endmodule

// File: rtl/fifo_busmatch_chk.sv
module fifo_busmatch_chk #(
  parameter int DEPTH9 = 64,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          mrst,
  input logic          prst,
  input logic          fwft,
  input logic          wen,
  input logic          wcs,
  input logic          ren,
  input logic          rcs,
  input logic          rt,
  input logic          mark_q,
  input logic          out_flag,
  input logic          in_flag,
  input logic          half_full,
  input logic [17:0]   dout,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] mptr
);
  wire [PW-1:0] occ = wptr - (mark_q ? mptr : rptr);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (mrst || prst)
    occ <= PW'(DEPTH9)); // R8
  AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (mrst || prst)
    !fwft && in_flag && wen |=> $stable(wptr)); // R8
  AST_WCS_GATES_WRITE: assert property (@(posedge clk) disable iff (mrst || prst)
    !wcs |=> $stable(wptr)); // R6
  AST_RCS_GATES_READ: assert property (@(posedge clk) disable iff (mrst || prst)
    !fwft && !rcs && !(rt && mark_q) |=> $stable(rptr) && $stable(dout)); // R7
  AST_EMPTY_HOLDS_DOUT: assert property (@(posedge clk) disable iff (mrst || prst)
    !fwft && out_flag && !(rt && mark_q) |=> $stable(dout)); // R14
  AST_REWIND_TO_MARK: assert property (@(posedge clk) disable iff (mrst || prst)
    rt && mark_q |=> rptr == $past(mptr)); // R11
  AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (mrst || prst)
    !fwft && half_full |-> !out_flag); // R9
  AST_FWFT_HOLDS_WORD: assert property (@(posedge clk) disable iff (mrst || prst)
    fwft && out_flag && !ren && !(rt && mark_q) |=> out_flag && $stable(dout)); // R10
endmodule

bind fifo_busmatch fifo_busmatch_chk #(.DEPTH9(DEPTH9), .PW(PW)) u_chk (
  .clk(clk), .mrst(mrst), .prst(prst), .fwft(fwft), .wen(wen), .wcs(wcs),
  .ren(ren), .rcs(rcs), .rt(rt), .mark_q(mark_q), .out_flag(out_flag),
  .in_flag(in_flag), .half_full(half_full), .dout(dout), .wptr(wptr),
  .rptr(rptr), .mptr(mptr)
);

// File: tb/test_fifo_busmatch.sv
`timescale 1ns/1ps
module test_fifo_busmatch;
  localparam int DEPTH9 = 64;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0;
  logic cfg_in_wide = 1'b0, cfg_out_wide = 1'b0, cfg_big_end = 1'b1, cfg_fwft = 1'b0;
  logic wen = 1'b0, wcs = 1'b1, ren = 1'b0, rcs = 1'b1, mark = 1'b0, rt = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic out_flag, in_flag, half_full;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  fifo_busmatch #(.DEPTH9(DEPTH9)) i_fifo_busmatch (
    .clk(clk), .mrst(mrst), .prst(prst), .cfg_in_wide(cfg_in_wide),
    .cfg_out_wide(cfg_out_wide), .cfg_big_end(cfg_big_end), .cfg_fwft(cfg_fwft),
    .wen(wen), .wcs(wcs), .din(din), .ren(ren), .rcs(rcs), .mark(mark), .rt(rt),
    .dout(dout), .out_flag(out_flag), .in_flag(in_flag), .half_full(half_full)
  );

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_mrst(logic iw, logic ow, logic be, logic ff);
    @(negedge clk);
    mrst = 1'b1; cfg_in_wide = iw; cfg_out_wide = ow; cfg_big_end = be; cfg_fwft = ff;
    @(negedge clk);
    @(negedge clk);
    mrst = 1'b0;
  endtask

  task automatic wr(logic [17:0] d);
    @(negedge clk);
    wen = 1'b1; din = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    ren = 1'b1;
    @(negedge clk);
    ren = 1'b0;
  endtask

  task automatic t_reset();
    do_mrst(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 std empty", 18'(out_flag), 18'd1);
    chk("R1 std full", 18'(in_flag), 18'd0);
    chk("R1 half", 18'(half_full), 18'd0);
    chk("R1 dout", dout, 18'd0);
    do_mrst(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1 fwft valid", 18'(out_flag), 18'd0);
    chk("R1 fwft ready", 18'(in_flag), 18'd1);
  endtask

  task automatic t_narrow();
    do_mrst(1'b0, 1'b0, 1'b1, 1'b0);
    wr(18'h3F_E11); wr(18'h012); wr(18'h013);
    rd(); chk("R2 first, upper ignored", dout, 18'h011);
    rd(); chk("R2 second", dout, 18'h012);
    rd(); chk("R2 third", dout, 18'h013);
    chk("R2 empty after", 18'(out_flag), 18'd1);
    rd(); chk("R14 read when empty", dout, 18'h013);
  endtask

  task automatic t_wide();
    do_mrst(1'b1, 1'b1, 1'b1, 1'b0);
    wr({9'h123, 9'h045}); wr({9'h1AB, 9'h0CD});
    rd(); chk("R3 word 0", dout, {9'h123, 9'h045});
    rd(); chk("R3 word 1", dout, {9'h1AB, 9'h0CD});
  endtask

  task automatic t_pack(logic be);
    do_mrst(1'b0, 1'b1, be, 1'b0);
    wr(18'h0A1);
    chk("R4 one byte not a word", 18'(out_flag), 18'd1);
    wr(18'h0B2);
    chk("R4 two bytes make a word", 18'(out_flag), 18'd0);
    rd();
    chk("R4 packed order", dout, be ? {9'h0A1, 9'h0B2} : {9'h0B2, 9'h0A1});
  endtask

  task automatic t_unpack(logic be);
    do_mrst(1'b1, 1'b0, be, 1'b0);
    wr({9'h111, 9'h022});
    rd(); chk("R5 first byte", dout, be ? 18'h111 : 18'h022);
    rd(); chk("R5 second byte", dout, be ? 18'h022 : 18'h111);
  endtask

  task automatic t_wcs();
    do_mrst(1'b0, 1'b0, 1'b1, 1'b0);
    wcs = 1'b0; wr(18'h007); wcs = 1'b1;
    chk("R6 deselected write ignored", 18'(out_flag), 18'd1);
    wr(18'h008);
    rd(); chk("R6 selected write stored", dout, 18'h008);
  endtask

  task automatic t_rcs();
    do_mrst(1'b0, 1'b0, 1'b1, 1'b0);
    wr(18'h009);
    rcs = 1'b0; rd(); rcs = 1'b1;
    chk("R7 dout held", dout, 18'h000);
    chk("R7 data kept", 18'(out_flag), 18'd0);
    rd(); chk("R7 selected read", dout, 18'h009);
  endtask

  task automatic t_full();
    do_mrst(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < DEPTH9; i++) begin
      wr(18'(i + 3));
      if (i == DEPTH9 / 2 - 1) chk("R9 half not yet", 18'(half_full), 18'd0);
      if (i == DEPTH9 / 2) chk("R9 half set", 18'(half_full), 18'd1);
      if (i == DEPTH9 - 2) chk("R8 one short of full", 18'(in_flag), 18'd0);
    end
    chk("R8 full", 18'(in_flag), 18'd1);
    wr(18'h1FF);
    for (int i = 0; i < DEPTH9; i++) begin
      rd();
      if (dout !== 18'(i + 3)) chk("R8 drain order", dout, 18'(i + 3));
    end
    checks++;
    chk("R8 overflow write dropped", 18'(out_flag), 18'd1);
    rd(); chk("R14 still last", dout, 18'(DEPTH9 + 2));
  endtask

  task automatic t_fwft();
    do_mrst(1'b0, 1'b0, 1'b1, 1'b1);
    wr(18'h055);
    @(negedge clk);
    chk("R10 falls through valid", 18'(out_flag), 18'd1);
    chk("R10 falls through data", dout, 18'h055);
    wr(18'h066);
    chk("R10 held without read", dout, 18'h055);
    rd(); chk("R10 next word", dout, 18'h066);
    chk("R10 still valid", 18'(out_flag), 18'd1);
    rd(); chk("R10 drained", 18'(out_flag), 18'd0);
  endtask

  task automatic t_mark();
    do_mrst(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 1; i <= 5; i++) wr(18'(16 + i));
    rd(); chk("R11 before mark", dout, 18'h011);
    @(negedge clk); mark = 1'b1;
    @(negedge clk);
    rd(); chk("R11 after mark", dout, 18'h012);
    rd(); chk("R11 after mark 2", dout, 18'h013);
    @(negedge clk); rt = 1'b1;
    @(negedge clk); rt = 1'b0;
    rd(); chk("R11 rewound", dout, 18'h012);
    rd(); chk("R11 replay", dout, 18'h013);
    @(negedge clk); mark = 1'b0;
    @(negedge clk); rt = 1'b1;
    @(negedge clk); rt = 1'b0;
    rd(); chk("R11 rt without mark ignored", dout, 18'h014);
  endtask

  task automatic t_mark_full();
    do_mrst(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) wr(18'(i));
    @(negedge clk); mark = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) rd();
    for (int i = 0; i < DEPTH9 - 4; i++) wr(18'(i));
    chk("R12 full against mark", 18'(in_flag), 18'd1);
    @(negedge clk); mark = 1'b0;
    @(negedge clk);
    chk("R12 space freed on release", 18'(in_flag), 18'd0);
  endtask

  task automatic t_prst();
    do_mrst(1'b1, 1'b0, 1'b0, 1'b0);
    wr({9'h0AA, 9'h055});
    @(negedge clk);
    prst = 1'b1; cfg_big_end = 1'b1; cfg_in_wide = 1'b0;
    @(negedge clk);
    prst = 1'b0;
    chk("R13 emptied", 18'(out_flag), 18'd1);
    wr({9'h0AA, 9'h055});
    rd(); chk("R13 order kept", dout, 18'h055);
    rd(); chk("R13 width kept", dout, 18'h0AA);
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_pack(1'b1);
    t_pack(1'b0);
    t_unpack(1'b1);
    t_unpack(1'b0);
    t_wcs();
    t_rcs();
    t_full();
    t_fwft();
    t_mark();
    t_mark_full();
    t_prst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule